// File: doc/BRIEF.md
# APB Write Commit Monitor

This block is a passive observer placed on an APB bus beside one subordinate's register bank. It drives nothing on the bus. It follows each transfer through its setup and access phases. It checks that the manager keeps address, direction and write data unchanged until the transfer completes. It identifies the single cycle on which a write lands, and it checks that each watched register changes only on such a cycle addressed to that register.

The monitor also holds a shadow copy of every watched register. A write commit loads the shadow copy. Each read completion to a mapped address is compared with the shadow copy, so a write that was acknowledged but did not take effect is caught at its next read-back. Faults are reported on sticky flags, which a synchronous clear pulse resets. A saturating counter records commits that came back with an error response. A per-register bit records that the register has been written at least once.

Register `i` sits at address `BASE + i*STRIDE`. The subordinate's register contents are presented to the monitor as one flat vector, with register `i` in bits `[i*DW +: DW]`.

Top module: `apb_wr_commit_mon`

## Requirements
- R1: While `rst_n` is low, and after it is released, every error flag, `slverr_cnt` and `commit_seen` are zero, and every shadow entry equals `SHADOW_RST`.
- R2: A commit is a cycle on which `psel`, `penable`, `pwrite` and `pready` are all high. After a commit whose `paddr` equals `BASE + i*STRIDE`, bit `i` of `commit_seen` is set from the next edge and stays set until reset. No other cycle sets it.
- R3: If `paddr`, `pwrite` or (for writes) `pwdata` on any access cycle differs from the value captured in the setup cycle, `err_stable` is set.
- R4: If a watched register's value differs from its value one cycle earlier, and the earlier cycle was not a commit to that register's address, `err_illegal` is set one edge after the new value first appears. This includes a change caused by a write during a wait cycle.
- R5: If a second commit-qualified cycle follows a write commit before any new setup cycle (`psel` high, `penable` low), `err_double` is set. The sequencing flag is not set for that cycle.
- R6: Each commit to a mapped address stores `pwdata` in that shadow entry. A commit to an unmapped address, including one whose low bits alias a mapped address, changes no shadow entry and no `commit_seen` bit.
- R7: On a read completion (`psel`, `penable`, `pready` high, `pwrite` low) to a mapped address, `err_readback` is set if `prdata` differs from the shadow entry.
- R8: Each commit with `pslverr` high adds one to `slverr_cnt`, which saturates at its all-ones value. Error-response commits still update the shadow and `commit_seen`.
- R9: An access cycle that does not follow a setup or wait cycle sets `err_seq`, except in the double-commit case of R5. So does `psel` dropping after a wait cycle in which `pready` was low.
- R10: Error flags stay set until `clr_flags` is sampled high, which zeroes them at that edge. A new fault in the same cycle still sets its flag. `clr_flags` leaves `slverr_cnt` and `commit_seen` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_flags | input | 1 | Synchronous clear of the error flags |
| psel | input | 1 | Observed select |
| penable | input | 1 | Observed enable |
| pwrite | input | 1 | Observed direction, high for write |
| pready | input | 1 | Observed ready |
| pslverr | input | 1 | Observed error response |
| paddr | input | AW | Observed address |
| pwdata | input | DW | Observed write data |
| prdata | input | DW | Observed read data |
| reg_vals | input | NREG*DW | Current contents of the watched registers |
| err_stable | output | 1 | Hold-until-completion violation |
| err_illegal | output | 1 | Watched register changed outside its commit |
| err_double | output | 1 | More than one commit in one transfer |
| err_readback | output | 1 | Read data differs from the shadow copy |
| err_seq | output | 1 | Phase sequencing violation |
| slverr_cnt | output | CW | Saturating count of error-response commits |
| commit_seen | output | NREG | Per-register written-at-least-once bits |

## Verification
The assertions assume that `reg_vals` comes from flops clocked by `clk`. Under that assumption a register that is written changes exactly one edge after its commit. They also assume that bus inputs change only between edges. The bench meets both assumptions: its subordinate model updates its registers in a clocked process, and it drives all bus inputs on the falling edge. Each fault is then provoked one at a time, and the flags are cleared before the next fault. This way each assertion that links a rising flag to the bus cycle before it sees one cause at a time.

// File: rtl/apb_wmon_pkg.sv
package apb_wmon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    localparam int FLAG_N      = 5;
    localparam int FL_STABLE   = 0;
    localparam int FL_ILLEGAL  = 1;
    localparam int FL_DOUBLE   = 2;
    localparam int FL_READBACK = 3;
    localparam int FL_SEQ      = 4;

endpackage

// File: rtl/apb_wmon_phase.sv
module apb_wmon_phase
    import apb_wmon_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic          pready,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic          commit,
    output logic          rd_done,
    output logic          stab_viol,
    output logic          seq_viol,
    output logic          dbl_viol
);

    typedef struct packed {
        phase_e        ph;
        logic          wdone;
        logic [AW-1:0] addr;
        logic          wr;
        logic [DW-1:0] wdata;
    } trk_t;

    trk_t trk_d, trk_q;
    logic setup_c, access_c, done_c, held_diff;

    always_comb begin
        trk_d    = trk_q;
        setup_c  = psel & ~penable;
        access_c = psel & penable;
        done_c   = access_c & pready;
        commit   = done_c & pwrite;
        rd_done  = done_c & ~pwrite;

        held_diff = (paddr != trk_q.addr) | (pwrite != trk_q.wr) |
                    (trk_q.wr & (pwdata != trk_q.wdata));
        stab_viol = access_c & (trk_q.ph != PH_IDLE) & held_diff;
        dbl_viol  = commit & (trk_q.ph == PH_IDLE) & trk_q.wdone;
        seq_viol  = (access_c & (trk_q.ph == PH_IDLE) & ~dbl_viol) |
                    ((trk_q.ph == PH_WAIT) & ~psel);

        if (setup_c) begin
            trk_d.ph    = PH_SETUP;
            trk_d.wdone = 1'b0;
            trk_d.addr  = paddr;
            trk_d.wr    = pwrite;
            trk_d.wdata = pwdata;
        end else if (access_c) begin
            if (trk_q.ph == PH_IDLE) begin
                trk_d.addr  = paddr;
                trk_d.wr    = pwrite;
                trk_d.wdata = pwdata;
            end
            trk_d.ph = pready ? PH_IDLE : PH_WAIT;
            if (commit) begin
                trk_d.wdone = 1'b1;
            end
        end else begin
            trk_d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/apb_wmon_decode.sv
module apb_wmon_decode #(
    parameter int          AW     = 12,
    parameter int          NREG   = 4,
    parameter int unsigned BASE   = 0,
    parameter int unsigned STRIDE = 4
) (
    input  logic [AW-1:0]   paddr,
    output logic [NREG-1:0] hit
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [AW-1:0] SLOT_ADDR = AW'(BASE + g * STRIDE);
        assign hit[g] = (paddr == SLOT_ADDR);
    end

endmodule

// File: rtl/apb_wmon_shadow.sv
module apb_wmon_shadow #(
    parameter int            NREG    = 4,
    parameter int            DW      = 32,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [NREG-1:0] hit,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   rdata,
    output logic            mismatch
);

    logic [DW-1:0] sh_d [NREG];
    logic [DW-1:0] sh_q [NREG];

    always_comb begin
        mismatch = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            sh_d[i] = sh_q[i];
            if (wr_en && hit[i]) begin
                sh_d[i] = wdata;
            end
            if (rd_en && hit[i] && (rdata != sh_q[i])) begin
                mismatch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                sh_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                sh_q[i] <= sh_d[i];
            end
        end
    end

endmodule

// File: rtl/apb_wr_commit_mon.sv
module apb_wr_commit_mon
    import apb_wmon_pkg::*;
#(
    parameter int            AW         = 12,
    parameter int            DW         = 32,
    parameter int            NREG       = 4,
    parameter int unsigned   BASE       = 0,
    parameter int unsigned   STRIDE     = 4,
    parameter int            CW         = 8,
    parameter logic [DW-1:0] SHADOW_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_flags,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic               pready,
    input  logic               pslverr,
    input  logic [AW-1:0]      paddr,
    input  logic [DW-1:0]      pwdata,
    input  logic [DW-1:0]      prdata,
    input  logic [NREG*DW-1:0] reg_vals,
    output logic               err_stable,
    output logic               err_illegal,
    output logic               err_double,
    output logic               err_readback,
    output logic               err_seq,
    output logic [CW-1:0]      slverr_cnt,
    output logic [NREG-1:0]    commit_seen
);

    localparam int VW = NREG * DW;

    typedef struct packed {
        logic [VW-1:0]     prev;
        logic              primed;
        logic [NREG-1:0]   hit_last;
        logic [FLAG_N-1:0] flags;
        logic [CW-1:0]     cnt;
        logic [NREG-1:0]   seen;
    } mon_t;

    mon_t st_d, st_q;

    logic              commit, rd_done, stab_viol, seq_viol, dbl_viol, rd_mism;
    logic [NREG-1:0]   hit, chg;
    logic [FLAG_N-1:0] ev;

    apb_wmon_phase #(.AW(AW), .DW(DW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .pready    (pready),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .commit    (commit),
        .rd_done   (rd_done),
        .stab_viol (stab_viol),
        .seq_viol  (seq_viol),
        .dbl_viol  (dbl_viol)
    );

    apb_wmon_decode #(.AW(AW), .NREG(NREG), .BASE(BASE), .STRIDE(STRIDE)) u_decode (
        .paddr (paddr),
        .hit   (hit)
    );

    apb_wmon_shadow #(.NREG(NREG), .DW(DW), .RST_VAL(SHADOW_RST)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit),
        .rd_en    (rd_done),
        .hit      (hit),
        .wdata    (pwdata),
        .rdata    (prdata),
        .mismatch (rd_mism)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_chg
        assign chg[g] = st_q.prev[g*DW +: DW] != reg_vals[g*DW +: DW];
    end

    always_comb begin
        st_d          = st_q;
        st_d.prev     = reg_vals;
        st_d.primed   = 1'b1;
        st_d.hit_last = commit ? hit : '0;

        ev              = '0;
        ev[FL_STABLE]   = stab_viol;
        ev[FL_ILLEGAL]  = st_q.primed & |(chg & ~st_q.hit_last);
        ev[FL_DOUBLE]   = dbl_viol;
        ev[FL_READBACK] = rd_mism;
        ev[FL_SEQ]      = seq_viol;

        st_d.flags = (clr_flags ? '0 : st_q.flags) | ev;

        if (commit) begin
            st_d.seen = st_q.seen | hit;
            if (pslverr && (st_q.cnt != '1)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_stable   = st_q.flags[FL_STABLE];
    assign err_illegal  = st_q.flags[FL_ILLEGAL];
    assign err_double   = st_q.flags[FL_DOUBLE];
    assign err_readback = st_q.flags[FL_READBACK];
    assign err_seq      = st_q.flags[FL_SEQ];
    assign slverr_cnt   = st_q.cnt;
    assign commit_seen  = st_q.seen;

endmodule

// File: rtl/apb_wmon_sva.sv
module apb_wmon_sva #(
    parameter int NREG = 4,
    parameter int CW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr_flags,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic            pready,
    input logic            pslverr,
    input logic            err_stable,
    input logic            err_illegal,
    input logic            err_double,
    input logic            err_readback,
    input logic            err_seq,
    input logic [CW-1:0]   slverr_cnt,
    input logic [NREG-1:0] commit_seen
);

    logic [4:0] flags_v;
    assign flags_v = {err_seq, err_readback, err_double, err_illegal, err_stable};

    AST_SEEN_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_seen != $past(commit_seen)) |-> $past(psel && penable && pwrite && pready)); // R2

    AST_SEEN_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(commit_seen) & ~commit_seen) == '0)); // R2

    AST_STABLE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_stable) |-> $past(psel && penable)); // R3

    AST_DOUBLE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_double) |-> $past(psel && penable && pwrite && pready)); // R5

    AST_READBACK_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_readback) |-> $past(psel && penable && pready && !pwrite)); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slverr_cnt != $past(slverr_cnt)) |->
        ($past(psel && penable && pwrite && pready && pslverr) &&
         (slverr_cnt == CW'($past(slverr_cnt) + 1'b1)))); // R8

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_flags) |-> ((flags_v & $past(flags_v)) == $past(flags_v))); // R10

endmodule

bind apb_wr_commit_mon apb_wmon_sva #(.NREG(NREG), .CW(CW)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_flags    (clr_flags),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .pready       (pready),
    .pslverr      (pslverr),
    .err_stable   (err_stable),
    .err_illegal  (err_illegal),
    .err_double   (err_double),
    .err_readback (err_readback),
    .err_seq      (err_seq),
    .slverr_cnt   (slverr_cnt),
    .commit_seen  (commit_seen)
);

// File: tb/apb_wr_commit_mon_test.sv
module apb_wr_commit_mon_test;

    localparam int AW   = 12;
    localparam int DW   = 32;
    localparam int NREG = 4;
    localparam int CW   = 2;

    logic               clk = 1'b0;
    logic               rst_n, clr_flags;
    logic               psel, penable, pwrite, pready, pslverr;
    logic [AW-1:0]      paddr;
    logic [DW-1:0]      pwdata, prdata;
    logic [NREG*DW-1:0] reg_vals;
    logic               err_stable, err_illegal, err_double, err_readback, err_seq;
    logic [CW-1:0]      slverr_cnt;
    logic [NREG-1:0]    commit_seen;

    logic [DW-1:0]      regs [NREG];
    logic               early_mode, bad_rd;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    apb_wr_commit_mon #(.AW(AW), .DW(DW), .NREG(NREG), .CW(CW)) uut (
        .clk (clk), .rst_n (rst_n), .clr_flags (clr_flags),
        .psel (psel), .penable (penable), .pwrite (pwrite), .pready (pready),
        .pslverr (pslverr), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .reg_vals (reg_vals), .err_stable (err_stable), .err_illegal (err_illegal),
        .err_double (err_double), .err_readback (err_readback), .err_seq (err_seq),
        .slverr_cnt (slverr_cnt), .commit_seen (commit_seen)
    );

    // Behavioural subordinate: registers at 0x0,0x4,0x8,0xC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (psel && penable && pwrite && (pready || early_mode)) begin
            for (int i = 0; i < NREG; i++)
                if (paddr == AW'(i * 4)) regs[i] <= pwdata;
        end
    end

    always_comb begin
        prdata = '0;
        for (int i = 0; i < NREG; i++) begin
            reg_vals[i*DW +: DW] = regs[i];
            if (paddr == AW'(i * 4)) prdata = bad_rd ? ~regs[i] : regs[i];
        end
    end

    typedef struct {
        string      req;
        logic [4:0] flags;
        int         cnt;
        logic [3:0] seen;
    } exp_t;

    exp_t sbq[$];

    int         e_cnt = 0;
    logic [3:0] e_seen = '0;

    task automatic push_exp(input string r, input logic [4:0] f);
        exp_t e;
        #1;
        e.req = r; e.flags = f; e.cnt = e_cnt; e.seen = e_seen;
        sbq.push_back(e);
    endtask

    // Monitor: compares queued expectations on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                exp_t e;
                logic [4:0] got;
                e = sbq.pop_front();
                got = {err_seq, err_readback, err_double, err_illegal, err_stable};
                n_chk++;
                if (got !== e.flags) begin
                    n_err++;
                    $display("FAIL %s flags{seq,rdbk,dbl,ill,stab}: got %b expected %b", e.req, got, e.flags);
                end
                n_chk++;
                if (int'(slverr_cnt) != e.cnt) begin
                    n_err++;
                    $display("FAIL %s slverr_cnt: got %0d expected %0d", e.req, slverr_cnt, e.cnt);
                end
                n_chk++;
                if (commit_seen !== e.seen) begin
                    n_err++;
                    $display("FAIL %s commit_seen: got %b expected %b", e.req, commit_seen, e.seen);
                end
            end
        end
    end

    task automatic go_idle();
        psel = 0; penable = 0; pwrite = 0; pready = 0; pslverr = 0;
    endtask

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int waits, input bit bump, input bit dbl, input bit serr);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wr ? d : '0;
        pready = 0; pslverr = 0;
        @(negedge clk);
        penable = 1; pready = (waits == 0); pslverr = serr && (waits == 0);
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            if (bump && w == 0) pwdata = pwdata ^ 32'h1;
            if (w == waits - 1) begin pready = 1; pslverr = serr; end
        end
        if (dbl) @(negedge clk);
        @(negedge clk);
        go_idle();
        @(posedge clk);
    endtask

    task automatic clear();
        @(negedge clk);
        clr_flags = 1;
        @(posedge clk);
        push_exp("R10 clear", 5'b0);
        @(negedge clk);
        clr_flags = 0;
    endtask

    initial begin
        rst_n = 0; clr_flags = 0; early_mode = 0; bad_rd = 0;
        paddr = '0; pwdata = '0;
        go_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        push_exp("R1 reset", 5'b0);

        xfer(1, 12'h000, 32'h1111_0000, 0, 0, 0, 0);
        e_seen[0] = 1;
        push_exp("R2 write reg0", 5'b0);

        xfer(0, 12'h000, '0, 0, 0, 0, 0);
        push_exp("R7 read reg0 matches", 5'b0);

        xfer(1, 12'h008, 32'h0000_A5A5, 3, 0, 0, 0);
        e_seen[2] = 1;
        push_exp("R4 waited write no false alarm", 5'b0);

        xfer(0, 12'h008, '0, 2, 0, 0, 0);
        push_exp("R6 read reg2 after waits", 5'b0);

        xfer(1, 12'h080, 32'hDEAD_BEEF, 0, 0, 0, 0);
        push_exp("R6 unmapped write seen unchanged", 5'b0);
        xfer(0, 12'h000, '0, 0, 0, 0, 0);
        push_exp("R6 shadow untouched by alias write", 5'b0);

        xfer(1, 12'h004, 32'h2222_0000, 1, 0, 0, 1);
        e_cnt = 1; e_seen[1] = 1;
        push_exp("R8 error response counted", 5'b0);

        xfer(1, 12'h00C, 32'h3333_0000, 2, 1, 0, 0);
        e_seen[3] = 1;
        push_exp("R3 data changed during wait", 5'b00001);
        clear();

        early_mode = 1;
        xfer(1, 12'h004, 32'h4444_0000, 2, 0, 0, 0);
        early_mode = 0;
        push_exp("R4 register changed on wait cycle", 5'b00010);
        clear();

        xfer(1, 12'h000, 32'h5555_0000, 0, 0, 1, 0);
        push_exp("R5 double commit without R9 flag", 5'b00100);
        clear();

        bad_rd = 1;
        xfer(0, 12'h008, '0, 0, 0, 0, 0);
        bad_rd = 0;
        push_exp("R7 read mismatch", 5'b01000);
        clear();

        // R9: access with no setup
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 0; pready = 1; paddr = 12'h008;
        @(negedge clk);
        go_idle();
        @(posedge clk);
        push_exp("R9 access without setup", 5'b10000);
        clear();

        // R9: select dropped during a wait
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h004; pwdata = 32'h6666_0000;
        @(negedge clk);
        penable = 1; pready = 0;
        @(negedge clk);
        go_idle();
        @(posedge clk);
        push_exp("R9 select dropped in wait", 5'b10000);
        clear();

        for (int k = 0; k < 3; k++) begin
            xfer(1, 12'h004, 32'h7000_0000 + k, 0, 0, 0, 1);
            if (e_cnt < 3) e_cnt++;
            push_exp("R8 counter saturation", 5'b0);
        end

        xfer(0, 12'h004, '0, 0, 0, 0, 0);
        push_exp("R6 shadow holds last error write", 5'b0);

        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule